// File: doc/BRIEF.md
# Paged Address Translator with Access Protection

This block sits between a CPU and its main memory. It turns 24-bit CPU addresses that fall in the lowest 4 MB into physical RAM addresses through a table of 1024 entries, one per 4 KB page. Before the access is let through, it checks the access against the page's residency state and write permission and against the CPU's privilege level. A denied access gets one of four fault classes. Each class carries its own combination of a level-7 interrupt request and a bus-error request.

The translation, the checks, the read-data fill and the RAM write strobe are combinational from the access inputs and the current table contents. Each table entry also keeps a referenced bit and a modified bit. These bits are updated at the clock edge that ends every access in the translated window, including accesses that fault. Software loads and inspects the table through a separate synchronous write / asynchronous read port. While the boot override input is low, every CPU address is pushed into the upper (ROM) half of the address space.

Top module: `pgmmu`

## Requirements
- R1: For an effective address below 0x400000, the physical address is the low 10 bits of table entry `ea[21:12]` followed by `ea[11:0]`. Each entry is 16 bits: bits [9:0] hold the physical page, bit 15 is write enable, bit 14 is the referenced bit (PS1) and bit 13 is the modified bit (PS0).
- R2: While `rom_map_en` is 0, bit 23 of the CPU address is forced to 1 before any check. Such an access never updates the table. For a user-mode access it is a user I/O fault.
- R3: An access in the window to an entry with PS1 = PS0 = 0 gives fault class 1 (page fault). It raises both `irq7` and `berr`, and it takes priority over every other class.
- R4: A user-mode access to an effective address below 0x080000 that is not a page fault gives class 2 (kernel protection). It raises `irq7` and `berr`.
- R5: A user-mode write in the window to an entry whose write-enable bit is clear gives class 3 (write protect), with `irq7` and `berr`. Supervisor writes and user reads to such a page are allowed (class 0, no request).
- R6: A user-mode access to an effective address of 0x400000 or above gives class 4 (user I/O). It raises `berr` only, never `irq7`.
- R7: Every valid access in the window sets PS1 in its entry at the closing clock edge, whether or not it faults.
- R8: On a non-faulting access in the window, PS0 becomes 1 only for a write to an entry whose PS1/PS0 was 01 or 10. Every other non-faulting access clears it.
- R9: A faulting access leaves PS0 unchanged. No access at or above 0x400000 changes any entry.
- R10: A denied read, a read whose physical page is at or above `RAM_PAGES` (default 512), or a read outside the window returns all ones in the low 8, 16 or 32 bits for `acc_size` 0, 1 or 2, with zeros above. An allowed RAM read returns `ram_rdata` masked the same way. `ram_we` goes high only for an allowed write in the window to an installed page.
- R11: Table entries reset to zero. A port write is visible to the access in the next cycle. An access in the same cycle still sees the old entry, and when both update the same entry, the port write wins. `map_rdata` shows entry `map_idx` without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the table |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 24 | CPU address |
| acc_size | input | 2 | 0 byte, 1 word, 2 long |
| acc_write | input | 1 | 1 write, 0 read |
| acc_super | input | 1 | 1 supervisor, 0 user |
| rom_map_en | input | 1 | Boot override; 0 forces address bit 23 high |
| ram_rdata | input | 32 | Data returned by RAM |
| map_we | input | 1 | Table write strobe |
| map_idx | input | 10 | Table entry index for the software port |
| map_wdata | input | 16 | Table write data |
| map_rdata | output | 16 | Table entry at `map_idx` |
| phys_addr | output | 22 | Translated physical address |
| acc_ok | output | 1 | Access allowed |
| fault_cls | output | 3 | 0 none, 1 page, 2 kernel, 3 write protect, 4 user I/O |
| irq7 | output | 1 | Level-7 interrupt request |
| berr | output | 1 | Bus-error request |
| ram_we | output | 1 | Write strobe toward RAM |
| cpu_rdata | output | 32 | Read data toward the CPU |

## Verification
The assertions assume that `acc_size` never takes the value 3 and that the access inputs are stable around each rising edge. They also assume a cycle with `acc_valid` low means no access at all, so the fault outputs must be quiet then. The bench drives every input just after a rising edge and holds it for the whole cycle. It uses only the three defined size codes. It loads table entries through the port before the accesses that depend on them, so each fault class and each PS1/PS0 transition is reached from a known entry value.

// File: rtl/pgmmu.sv
module pgmmu #(
  parameter int PN_W      = 10,
  parameter int OFS_W     = 12,
  parameter int ENT_W     = 16,
  parameter int WE_POS    = 15,
  parameter int PS1_POS   = 14,
  parameter int PS0_POS   = 13,
  parameter int RAM_PAGES = 512,
  parameter logic [23:0] KERN_TOP = 24'h080000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [23:0]      acc_addr,
  input  logic [1:0]       acc_size,
  input  logic             acc_write,
  input  logic             acc_super,
  input  logic             rom_map_en,
  input  logic [31:0]      ram_rdata,
  input  logic             map_we,
  input  logic [PN_W-1:0]  map_idx,
  input  logic [ENT_W-1:0] map_wdata,
  output logic [ENT_W-1:0] map_rdata,
  output logic [PN_W+OFS_W-1:0] phys_addr,
  output logic             acc_ok,
  output logic [2:0]       fault_cls,
  output logic             irq7,
  output logic             berr,
  output logic             ram_we,
  output logic [31:0]      cpu_rdata
);
  localparam int ENTRIES = 1 << PN_W;
  localparam int LA_W    = PN_W + OFS_W;

  logic [ENT_W-1:0] pmap [ENTRIES];
  logic [23:0]      ea;
  logic [PN_W-1:0]  aidx;
  logic [ENT_W-1:0] ent, nxt_ent;
  logic [1:0]       ps;
  logic             in_win, f_pg, f_kn, f_wp, f_io, ram_hit;
  logic [2:0]       cls;
  logic [31:0]      wmask;

  assign ea      = {acc_addr[23] | ~rom_map_en, acc_addr[22:0]};
  assign in_win  = (ea[23:LA_W] == '0);
  assign aidx    = ea[LA_W-1:OFS_W];
  assign ent     = pmap[aidx];
  assign ps      = {ent[PS1_POS], ent[PS0_POS]};

  assign f_pg = in_win && (ps == 2'b00);
  assign f_kn = !acc_super && (ea < KERN_TOP);
  assign f_wp = !acc_super && acc_write && in_win && !ent[WE_POS];
  assign f_io = !acc_super && !in_win;

  always_comb begin
    if (!acc_valid) cls = 3'd0;
    else if (f_pg)  cls = 3'd1;
    else if (f_kn)  cls = 3'd2;
    else if (f_wp)  cls = 3'd3;
    else if (f_io)  cls = 3'd4;
    else            cls = 3'd0;
  end

  always_comb begin
    case (acc_size)
      2'd0:    wmask = 32'h0000_00FF;
      2'd1:    wmask = 32'h0000_FFFF;
      default: wmask = 32'hFFFF_FFFF;
    endcase
  end

  assign ram_hit   = in_win && (int'(ent[PN_W-1:0]) < RAM_PAGES);
  assign fault_cls = cls;
  assign acc_ok    = acc_valid && (cls == 3'd0);
  assign irq7      = (cls == 3'd1) || (cls == 3'd2) || (cls == 3'd3);
  assign berr      = (cls != 3'd0);
  assign phys_addr = {ent[PN_W-1:0], ea[OFS_W-1:0]};
  assign ram_we    = acc_ok && acc_write && ram_hit;
  assign cpu_rdata = (acc_ok && !acc_write && ram_hit) ? (ram_rdata & wmask) : wmask;
  assign map_rdata = pmap[map_idx];

  always_comb begin
    nxt_ent = ent;
    nxt_ent[PS1_POS] = 1'b1;
    if (cls == 3'd0) nxt_ent[PS0_POS] = acc_write && (ps[1] ^ ps[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) pmap[i] <= '0;
    end else begin
      if (acc_valid && in_win) pmap[aidx] <= nxt_ent;
      if (map_we) pmap[map_idx] <= map_wdata;
    end
  end
endmodule

// File: rtl/pgmmu_chk.sv
module pgmmu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic        acc_ok,
  input logic [2:0]  fault_cls,
  input logic        irq7,
  input logic        berr,
  input logic        ram_we,
  input logic [31:0] cpu_rdata
);
  p_irq_has_berr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq7 |-> berr);

  p_uio_berr_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cls == 3'd4) |-> (berr && !irq7));

  p_allowed_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |-> (!berr && !irq7 && fault_cls == 3'd0));

  p_we_needs_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (acc_ok && acc_write));

  p_deny_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !acc_ok) |-> (cpu_rdata[7:0] == 8'hFF));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!berr && !irq7 && !ram_we && fault_cls == 3'd0));
endmodule

bind pgmmu pgmmu_chk u_chk (.*);

// File: tb/test_pgmmu.sv
`timescale 1ns/1ps
module test_pgmmu;
  localparam logic [31:0] RAMD = 32'hA5C3_1E77;

  logic        clk = 0, rst_n = 0;
  logic        acc_valid = 0, acc_write = 0, acc_super = 1, rom_map_en = 1;
  logic [23:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] ram_rdata = RAMD;
  logic        map_we = 0;
  logic [9:0]  map_idx = '0;
  logic [15:0] map_wdata = '0;
  logic [15:0] map_rdata;
  logic [21:0] phys_addr;
  logic        acc_ok, irq7, berr, ram_we;
  logic [2:0]  fault_cls;
  logic [31:0] cpu_rdata;

  logic [15:0] m_map [1024];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgmmu i_pgmmu (.*);

  task automatic cmp(string tag, string what, longint act, longint exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(string tag, bit v, logic [23:0] a, logic [1:0] sz, bit w, bit s,
                       bit rme, bit mw = 0, logic [9:0] midx = '0, logic [15:0] mdat = '0);
    logic [23:0] ea;
    logic [15:0] e, e2;
    logic [9:0]  idx;
    logic [31:0] mask;
    bit inw, hit, ok;
    int cls;
    acc_valid = v; acc_addr = a; acc_size = sz; acc_write = w; acc_super = s;
    rom_map_en = rme; map_we = mw; map_idx = midx; map_wdata = mdat;
    @(negedge clk);
    ea  = rme ? a : (a | 24'h800000);
    inw = ea < 24'h400000;
    idx = ea[21:12];
    e   = m_map[idx];
    if (!v) cls = 0;
    else if (inw && !e[14] && !e[13]) cls = 1;
    else if (!s && ea < 24'h080000) cls = 2;
    else if (!s && w && inw && !e[15]) cls = 3;
    else if (!s && !inw) cls = 4;
    else cls = 0;
    ok   = v && cls == 0;
    hit  = inw && (e[9:0] < 10'd512);
    mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    vectors++;
    cmp(tag, "fault_cls", fault_cls, cls);
    cmp(tag, "acc_ok", acc_ok, ok);
    cmp(tag, "irq7", irq7, (cls >= 1 && cls <= 3));
    cmp(tag, "berr", berr, cls != 0);
    cmp(tag, "ram_we", ram_we, ok && w && hit);
    cmp(tag, "cpu_rdata", cpu_rdata, (ok && !w && hit) ? (RAMD & mask) : mask);
    if (v && inw) cmp(tag, "phys_addr", phys_addr, {e[9:0], ea[11:0]});
    @(posedge clk);
    if (v && inw) begin
      e2 = e;
      e2[14] = 1'b1;
      if (cls == 0) e2[13] = w && (e[14] ^ e[13]);
      m_map[idx] = e2;
    end
    if (mw) m_map[midx] = mdat;
    #1;
    map_we = 0;
    acc_valid = 0;
  endtask

  task automatic map_wr(logic [9:0] idx, logic [15:0] d);
    apply("R11", 0, 24'h0, 2'd0, 0, 1, 1, 1, idx, d);
  endtask

  task automatic map_chk(string tag, logic [9:0] idx);
    acc_valid = 0; map_we = 0; map_idx = idx;
    @(negedge clk);
    vectors++;
    cmp(tag, "map_rdata", map_rdata, m_map[idx]);
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) m_map[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // reset state
    map_chk("R11", 10'h000);
    map_chk("R11", 10'h1FF);
    apply("R11", 0, 24'h100ABC, 2'd2, 0, 1, 1);
    // R1 translation and R8 PS0 transitions
    map_wr(10'h100, 16'hA005);
    apply("R1", 1, 24'h100ABC, 2'd2, 0, 1, 1);
    map_chk("R7", 10'h100);
    apply("R8", 1, 24'h100010, 2'd2, 1, 1, 1);
    map_chk("R8", 10'h100);
    apply("R8", 1, 24'h100020, 2'd1, 1, 1, 1);
    map_chk("R8", 10'h100);
    apply("R10", 1, 24'h100002, 2'd1, 0, 1, 1);
    apply("R10", 1, 24'h100003, 2'd0, 0, 1, 1);
    // R3 page fault and its priority
    map_wr(10'h200, 16'h0007);
    apply("R3", 1, 24'h200004, 2'd0, 0, 1, 1);
    map_chk("R9", 10'h200);
    apply("R3", 1, 24'h010000, 2'd1, 0, 0, 1);
    // R4 kernel protection
    map_wr(10'h020, 16'hA003);
    apply("R4", 1, 24'h020000, 2'd1, 0, 0, 1);
    map_chk("R9", 10'h020);
    // R5 write protect
    map_wr(10'h150, 16'h6008);
    apply("R5", 1, 24'h150020, 2'd2, 1, 0, 1);
    map_chk("R9", 10'h150);
    apply("R5", 1, 24'h150020, 2'd2, 1, 1, 1);
    map_chk("R8", 10'h150);
    apply("R5", 1, 24'h150040, 2'd2, 0, 0, 1);
    // R6 user I/O
    apply("R6", 1, 24'h600000, 2'd2, 0, 0, 1);
    apply("R6", 1, 24'h400000, 2'd1, 1, 0, 1);
    apply("R6", 1, 24'h600000, 2'd2, 0, 1, 1);
    map_chk("R9", 10'h200);
    // R2 boot override
    apply("R2", 1, 24'h100ABC, 2'd2, 0, 1, 0);
    map_chk("R2", 10'h100);
    apply("R2", 1, 24'h000100, 2'd1, 0, 0, 0);
    // R10 beyond installed RAM
    map_wr(10'h300, 16'hE3F0);
    apply("R10", 1, 24'h300000, 2'd2, 0, 1, 1);
    apply("R10", 1, 24'h300004, 2'd2, 1, 1, 1);
    // R11 same-cycle port write wins
    apply("R11", 1, 24'h100000, 2'd2, 1, 1, 1, 1, 10'h100, 16'h2011);
    map_chk("R11", 10'h100);
    apply("R11", 1, 24'h100FFC, 2'd2, 0, 1, 1);
    apply("R7", 1, 24'h3FF000, 2'd0, 0, 1, 1);
    map_chk("R7", 10'h3FF);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule